// File: doc/BRIEF.md
# Vectorized Linear-FM Chirp NCO

This block synthesizes a real-valued linear frequency-modulated (chirp) waveform for a converter. The converter takes several samples on every fabric clock. With the defaults it delivers 16 consecutive samples per 256 MHz beat, which is a 4096 MSPS stream. Within a pulse, the frequency of the output starts at a programmed start word. It then rises by a programmed step word on every single sample, not on every beat.

Two 32-bit accumulators carry the state from beat to beat: a base phase and a base frequency. Each lane adds its own first-order and second-order offset to the base phase, and the top bits of the result address a quarter-wave sine table. A restart strobe rewinds the phase and reloads the start frequency. While the enable input is low, every lane is silent and the accumulators hold.

The pulse framing is left to the surrounding logic, which drives the restart strobe and the enable.

Top module: `chirp_vec_nco`

## Requirements
- R1: After reset, every lane of `samples_out` is zero, and the phase and frequency accumulators are zero.
- R2: Lane k occupies bits [16k+15:16k] of `samples_out`, and lane 0 is the earliest sample in time within the beat.
- R3: For a beat with base phase P, base frequency F and step D, the phase of lane k is P + k·F + (k·(k−1)/2)·D, taken modulo 2^32.
- R4: After an enabled beat, P becomes P + 16·F + 120·D and F becomes F + 16·D, both modulo 2^32. This holds even when `step_word` changes between beats.
- R5: When `restart` is high, that cycle's beat uses P = 0 and F = `start_word`, and it advances from those values if enabled. `restart` takes priority over the held state.
- R6: While `enable` is low, the matching beat outputs zero on all lanes, and P and F hold their values (or take the restart values if `restart` is high).
- R7: A sample is the signed 16-bit value round(32767·sin(2π·(a+0.5)/1024)), within ±2 LSB, where a is phase bits [31:22]. The table stores one quadrant only. Addresses a and 511−a give equal magnitudes, and addresses a and a+512 give opposite signs. The code −32768 never appears.
- R8: Inputs sampled on one rising edge appear on `samples_out` after the second rising edge that follows. `enable` is delayed by the same two stages.
- R9: A start word of 1305·2^20 with a step word of 384 sweeps from 1305 MHz to 1320 MHz over 2560 beats, which is 10 µs at 4096 MSPS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, one beat per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Rewind phase to 0 and reload the start frequency |
| enable | input | 1 | Pulse gate; output is zero while low |
| start_word | input | 32 | Start frequency as a phase increment per sample |
| step_word | input | 32 | Frequency increment per sample |
| samples_out | output | 256 | 16 lanes of signed 16-bit samples, lane 0 in the low bits |

## Verification
Five stimulus patterns are used, and each exposes a different class of fault.

- A constant increment of 2^22 with zero step walks every table address exactly once across the lanes. This exposes quadrant mirroring, sign errors and lane ordering.
- The nominal 10 µs chirp runs for 2560 beats. Any error in the beat-to-beat advance terms accumulates over the run and shows up as a phase drift.
- Random start and step words, including negative steps and words near wrap-around, separate the second-order lane term from a plain tone. This pattern also checks that arithmetic wraps modulo 2^32.
- Enable gaps and mid-pulse restarts, issued with enable both high and low, reveal whether the accumulators hold while disabled, whether the two-stage enable delay is correct, and whether restart takes priority.
- Changing `step_word` in the middle of a pulse checks that the step is taken on each beat and not latched at restart.

// File: rtl/chirp_vec_nco.sv
module chirp_vec_nco #(
  parameter int LANES = 16,
  parameter int PW    = 32,
  parameter int AW    = 10,
  parameter int OW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  enable,
  input  logic [PW-1:0]         start_word,
  input  logic [PW-1:0]         step_word,
  output logic [LANES*OW-1:0]   samples_out
);
  localparam int  QB    = AW - 2;
  localparam int  QN    = 1 << QB;
  localparam int  TRI   = LANES * (LANES - 1) / 2;
  localparam longint AMP = (64'sd1 <<< (OW - 1)) - 1;

  function automatic logic [OW-1:0] qsin(input int i);
    longint one, pi_fx, th, t2, a, s;
    one   = 64'sd1 <<< 30;
    pi_fx = 64'sd3373259426;
    th    = (longint'(2 * i + 1) * pi_fx) / longint'(4 * QN);
    t2    = (th * th) >>> 30;
    a     = one - t2 / 72;
    a     = one - ((t2 * a) >>> 30) / 42;
    a     = one - ((t2 * a) >>> 30) / 20;
    a     = one - ((t2 * a) >>> 30) / 6;
    s     = (th * a) >>> 30;
    return OW'((s * AMP + (64'sd1 <<< 29)) >>> 30);
  endfunction

  logic [OW-1:0] qtab [QN];
  for (genvar i = 0; i < QN; i++) begin : g_tab
    localparam logic [OW-1:0] QV = qsin(i);
    assign qtab[i] = QV;
  end

  logic [PW-1:0] acc_p, acc_f;
  logic [PW-1:0] cur_p, cur_f;
  logic [PW-1:0] ph_q [LANES];
  logic          en_q;

  assign cur_p = restart ? '0 : acc_p;
  assign cur_f = restart ? start_word : acc_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_p <= '0;
      acc_f <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= enable;
      if (enable) begin
        acc_p <= cur_p + PW'(LANES) * cur_f + PW'(TRI) * step_word;
        acc_f <= cur_f + PW'(LANES) * step_word;
      end else begin
        acc_p <= cur_p;
        acc_f <= cur_f;
      end
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [PW-1:0] LIN = PW'(k);
    localparam logic [PW-1:0] SQ  = PW'(k * (k - 1) / 2);
    logic [AW-1:0] addr;
    logic [QB-1:0] idx;
    logic [OW-1:0] mag;

    always_ff @(posedge clk) begin
      if (!rst_n) ph_q[k] <= '0;
      else        ph_q[k] <= cur_p + LIN * cur_f + SQ * step_word;
    end

    assign addr = ph_q[k][PW-1 -: AW];
    assign idx  = addr[AW-2] ? ~addr[QB-1:0] : addr[QB-1:0];
    assign mag  = qtab[idx];

    always_ff @(posedge clk) begin
      if (!rst_n || !en_q) samples_out[k*OW +: OW] <= '0;
      else                 samples_out[k*OW +: OW] <= addr[AW-1] ? -mag : mag;
    end
  end
endmodule

module chirp_vec_nco_chk #(
  parameter int LANES = 16,
  parameter int PW    = 32,
  parameter int OW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                restart,
  input logic                enable,
  input logic [PW-1:0]       start_word,
  input logic [PW-1:0]       step_word,
  input logic [LANES*OW-1:0] samples_out,
  input logic [PW-1:0]       acc_p,
  input logic [PW-1:0]       acc_f
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n)        cyc <= '0;
    else if (cyc != 3) cyc <= cyc + 2'd1;
  end

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2 && !$past(enable, 2)) |-> (samples_out == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 1 && !$past(enable) && !$past(restart)) |-> (acc_p == $past(acc_p) && acc_f == $past(acc_f)));

  assert_restart_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 1 && $past(restart) && !$past(enable)) |-> (acc_p == '0 && acc_f == $past(start_word)));

  assert_freq_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 1 && $past(enable) && !$past(restart))
      |-> (acc_f == $past(acc_f) + PW'(LANES) * $past(step_word)));

  assert_restart_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2 && $past(restart, 2) && $past(enable, 2))
      |-> ($signed(samples_out[OW-1:0]) > 0 && $signed(samples_out[OW-1:0]) < 128));

  for (genvar k = 0; k < LANES; k++) begin : g_rng
    assert_no_min_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      samples_out[k*OW +: OW] != {1'b1, {(OW-1){1'b0}}});
  end
endmodule

bind chirp_vec_nco chirp_vec_nco_chk #(.LANES(LANES), .PW(PW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .enable(enable),
  .start_word(start_word), .step_word(step_word), .samples_out(samples_out),
  .acc_p(acc_p), .acc_f(acc_f)
);

// File: tb/chirp_vec_nco_bench.sv
module chirp_vec_nco_bench;
  localparam int L = 16;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, enable = 1'b0;
  logic [31:0] start_word = '0, step_word = '0;
  logic [L*W-1:0] samples_out;

  int vectors = 0, miscompares = 0;
  longint unsigned mp = 0, mf = 0;
  int    pipe0 [L];
  int    pipe1 [L];
  string tag0 = "R1", tag1 = "R1";

  always #5 clk = ~clk;

  chirp_vec_nco u_chirp_vec_nco (
    .clk(clk), .rst_n(rst_n), .restart(restart), .enable(enable),
    .start_word(start_word), .step_word(step_word), .samples_out(samples_out)
  );

  function automatic int ref_sin(input longint unsigned ph);
    int  a;
    real r;
    a = int'((ph >> 22) & 64'h3FF);
    r = 32767.0 * $sin(2.0 * 3.14159265358979 * (real'(a) + 0.5) / 1024.0);
    return $rtoi(r >= 0.0 ? r + 0.5 : r - 0.5);
  endfunction

  task automatic compare();
    int bad = -1, act = 0;
    vectors++;
    for (int k = 0; k < L; k++) begin
      int v = int'($signed(samples_out[k*W +: W]));
      int d = v - pipe1[k];
      if ((d > 2 || d < -2) && bad < 0) begin bad = k; act = v; end
    end
    if (bad >= 0) begin
      miscompares++;
      $display("FAIL %s vector %0d lane %0d: actual %0d expected %0d", tag1, vectors, bad, act, pipe1[bad]);
    end
  endtask

  task automatic beat(input bit rs, input bit en, input logic [31:0] sw, input logic [31:0] dw, input string tag);
    longint unsigned cp, cf, d, m;
    @(negedge clk);
    compare();
    pipe1 = pipe0;
    tag1  = tag0;
    restart = rs; enable = en; start_word = sw; step_word = dw;
    m  = 64'hFFFF_FFFF;
    d  = 64'(dw);
    cp = rs ? 0 : mp;
    cf = rs ? 64'(sw) : mf;
    for (int k = 0; k < L; k++)
      pipe0[k] = en ? ref_sin((cp + longint'(k) * cf + longint'(k * (k - 1) / 2) * d) & m) : 0;
    tag0 = tag;
    if (en) begin
      mp = (cp + 16 * cf + 120 * d) & m;
      mf = (cf + 16 * d) & m;
    end else begin
      mp = cp;
      mf = cf;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R8 watchdog: actual cycle count 200000 expected run end earlier");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int k = 0; k < L; k++) begin pipe0[k] = 0; pipe1[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, outputs zero
    for (int i = 0; i < 4; i++) beat(0, 0, 32'h1234_5678, 32'h9, "R1");
    // R6: idle with varying words, including a restart while idle
    for (int i = 0; i < 6; i++) beat(i == 2, 0, $urandom, $urandom, "R6");
    // R2 R7: one address per sample, full table sweep over 64 beats
    beat(1, 1, 32'h0040_0000, 32'h0, "R8");
    for (int i = 0; i < 70; i++) beat(0, 1, 32'h0040_0000, 32'h0, i < 34 ? "R2" : "R7");
    // R9 R4: nominal chirp 1305 MHz -> 1320 MHz over 2560 beats
    beat(1, 1, 32'd1368391680, 32'd384, "R5");
    for (int i = 0; i < 2560; i++) beat(0, 1, 32'd1368391680, 32'd384, i < 1280 ? "R4" : "R9");
    // R6: enable gap mid-pulse, then resume
    for (int i = 0; i < 5; i++) beat(0, 0, 32'd0, 32'd384, "R6");
    for (int i = 0; i < 20; i++) beat(0, 1, 32'd0, 32'd384, "R6");
    // R3: random start and step words, including negative steps and wrap
    for (int t = 0; t < 12; t++) begin
      logic [31:0] sw, dw;
      sw = $urandom;
      dw = (t % 3 == 0) ? -($urandom % 32'h0010_0000) : ($urandom % 32'h0100_0000);
      beat(1, 1, sw, dw, "R5");
      for (int i = 0; i < 30; i++) beat(0, 1, sw, dw, "R3");
    end
    // R4: step word changed every few beats within one pulse
    beat(1, 1, 32'hFFF0_0000, 32'h0000_1000, "R5");
    for (int i = 0; i < 40; i++) beat(0, 1, 32'h0, 32'h0000_1000 * (i / 8 + 1), "R4");
    // R5: restart asserted mid-pulse with enable high, and again with enable low
    for (int i = 0; i < 10; i++) beat(i == 4, 1, 32'h2000_0000, 32'h0000_0800, "R5");
    beat(1, 0, 32'h3000_0000, 32'h0000_0100, "R5");
    for (int i = 0; i < 10; i++) beat(0, 1, 32'h0, 32'h0000_0100, "R5");
    // R8: drain through the pipeline with enable low
    for (int i = 0; i < 4; i++) beat(0, 0, 32'h0, 32'h0, "R8");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule